// File: doc/BRIEF.md
# Consumer Channel-Status Bit Generator

This block supplies the channel-status bit that a digital audio transmitter inserts into each subframe. It stores a 192-bit status block for channel A (left) and a separate one for channel B (right). The fields are the ones a plain consumer stream needs: copying allowed, the general category, a channel number and the 32 kHz sample-rate code. Each block is grouped as 24 bytes. The transmitter presents the position of the current frame in the 192-frame block and a channel select. The block returns the matching status bit in the same cycle.

The last byte of each block is a checksum. After reset, a small sequencer walks both blocks one bit per clock and builds that checksum. It uses an 8-bit reflected CRC that starts from 0xFF, with 0xB8 as the feedback constant. The sequencer has three states. CRC_CHAN_A walks the 192 bits of channel A. It then takes transition A_TO_B into CRC_CHAN_B, which walks channel B. After that, transition B_TO_DONE leads to CRC_DONE, which it never leaves until reset. While the sequencer is walking, the checksum byte is read as zero. The output stays at zero and the ready flag stays low until CRC_DONE is reached.

Top module: `cs_bit_gen`

## Requirements
- R1: While reset is held, and after it until ready rises, `ready` is 0 and `status_bit` is 0 for every `frame_idx`.
- R2: `ready` rises right after the 384th rising clock edge that follows reset release (192 bits for channel A, then 192 for channel B). It then stays at 1 until the next reset.
- R3: Once ready, the bit returned for frame n is bit (n mod 8) of status byte (n div 8). Bit 0 is the least significant bit.
- R4: Byte 0 is 0x04 for both channels. Only bit 2 (copy permitted) is set, so frame 2 reads 1 and frames 0, 1 and 3 to 7 read 0.
- R5: Byte 1 (category) and bytes 4 to 22 are zero for both channels.
- R6: The upper nibble of byte 2 is the channel number: 1 when `chan_sel`=0 (byte 0x10, frame 20 set) and 2 when `chan_sel`=1 (byte 0x20, frame 21 set).
- R7: Byte 3 is 0x03 for both channels. Bits 0 and 1 together are the 32 kHz rate code, so frames 24 and 25 read 1.
- R8: Byte 23 of each channel holds a CRC over that channel's 24 bytes, with byte 23 taken as zero. The CRC starts at 0xFF. Data bits are taken least significant first within each byte, bytes in ascending order. For each bit, if CRC bit 0 XOR the data bit is 1, the CRC shifts right and is XORed with 0xB8; otherwise it only shifts right.
- R9: A `frame_idx` of 192 or more returns 0, even when ready.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| frame_idx | input | 8 | Frame position within the 192-frame block |
| chan_sel | input | 1 | 0 selects channel A (left), 1 selects channel B (right) |
| status_bit | output | 1 | Channel-status bit for the addressed frame and channel |
| ready | output | 1 | High once both CRC bytes are complete |

## Verification
The bench sweeps all 192 frames of both channels. This exposes a most-significant-first bit mapping, which would move the copy bit from frame 2 to frame 5. It also exposes swapped channel numbers, which would exchange frames 20 and 21. The CRC byte is compared against a model computed in the bench. A wrong feedback constant, initial value or bit order, or a failure to treat byte 23 as zero, shows up as a wrong pattern in frames 184 to 191. Ready is sampled on both sides of the 384th edge, so an off-by-one bit counter, or a counter that skips the second channel, fires early or late. Reads while not ready and reads at frame indexes 192 to 255 catch missing gating and a missing range check.

// File: rtl/cs_pkg.sv
package cs_pkg;
    localparam int CS_FRAMES     = 192;
    localparam int CS_BYTE_W     = 8;
    localparam int CS_CRC_BYTE   = 23;
    localparam logic [7:0] CS_CRC_INIT = 8'hFF;
    localparam logic [7:0] CS_CRC_POLY = 8'hB8;
    localparam int CS_COPY_BIT   = 2;
    localparam logic [3:0] CS_CHNUM_A = 4'd1;
    localparam logic [3:0] CS_CHNUM_B = 4'd2;
    localparam logic [7:0] CS_RATE_32K = 8'h03;

    typedef enum logic [1:0] {
        CRC_CHAN_A = 2'd0,
        CRC_CHAN_B = 2'd1,
        CRC_DONE   = 2'd2
    } crc_state_e;
endpackage

// File: rtl/cs_field_rom.sv
module cs_field_rom
    import cs_pkg::*;
#(
    parameter int BYTE_IDX_W = 5
) (
    input  logic [BYTE_IDX_W-1:0] byte_idx,
    input  logic                  chan,
    input  logic [7:0]            crc_a,
    input  logic [7:0]            crc_b,
    output logic [7:0]            byte_val
);
    always_comb begin
        byte_val = '0;
        if (byte_idx == BYTE_IDX_W'(0)) begin
            byte_val[CS_COPY_BIT] = 1'b1;
        end else if (byte_idx == BYTE_IDX_W'(2)) begin
            byte_val = {(chan ? CS_CHNUM_B : CS_CHNUM_A), 4'b0000};
        end else if (byte_idx == BYTE_IDX_W'(3)) begin
            byte_val = CS_RATE_32K;
        end else if (byte_idx == BYTE_IDX_W'(CS_CRC_BYTE)) begin
            byte_val = chan ? crc_b : crc_a;
        end
    end
endmodule

// File: rtl/cs_crc_seq.sv
module cs_crc_seq
    import cs_pkg::*;
#(
    parameter int FRAMES = CS_FRAMES,
    parameter logic [7:0] CRC_INIT = CS_CRC_INIT,
    parameter logic [7:0] CRC_POLY = CS_CRC_POLY,
    localparam int IDX_W = $clog2(FRAMES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             data_bit,
    output logic [IDX_W-1:0] scan_idx,
    output logic             scan_chan,
    output logic [7:0]       crc_a,
    output logic [7:0]       crc_b,
    output logic             done
);
    crc_state_e        state_q, state_d;
    logic [IDX_W-1:0]  cnt_q;
    logic [7:0]        crc_q, crc_step;
    logic              last_bit;

    assign last_bit = (cnt_q == IDX_W'(FRAMES - 1));
    assign crc_step = (crc_q[0] ^ data_bit) ? ((crc_q >> 1) ^ CRC_POLY) : (crc_q >> 1);

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CRC_CHAN_A: if (last_bit) state_d = CRC_CHAN_B;  // A_TO_B
            CRC_CHAN_B: if (last_bit) state_d = CRC_DONE;    // B_TO_DONE
            CRC_DONE:   state_d = CRC_DONE;
            default:    state_d = CRC_CHAN_A;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CRC_CHAN_A;
        else        state_q <= state_d;
    end

    // datapath: bit counter, running CRC, captured results
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            crc_q <= CRC_INIT;
            crc_a <= '0;
            crc_b <= '0;
        end else if (state_q != CRC_DONE) begin
            if (last_bit) begin
                cnt_q <= '0;
                crc_q <= CRC_INIT;
                if (state_q == CRC_CHAN_A) crc_a <= crc_step;
                else                       crc_b <= crc_step;
            end else begin
                cnt_q <= cnt_q + 1'b1;
                crc_q <= crc_step;
            end
        end
    end

    // outputs
    always_comb begin
        scan_idx  = cnt_q;
        scan_chan = (state_q == CRC_CHAN_B);
        done      = (state_q == CRC_DONE);
    end
endmodule

// File: rtl/cs_bit_gen.sv
module cs_bit_gen
    import cs_pkg::*;
#(
    parameter int FRAMES = CS_FRAMES,
    localparam int IDX_W = $clog2(FRAMES),
    localparam int BYTE_IDX_W = IDX_W - 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] frame_idx,
    input  logic             chan_sel,
    output logic             status_bit,
    output logic             ready
);
    logic [IDX_W-1:0] scan_idx;
    logic             scan_chan;
    logic [7:0]       scan_byte, rd_byte;
    logic [7:0]       crc_a_w, crc_b_w;
    logic             scan_bit, crc_done;

    // contents seen by the CRC walk: checksum byte read as zero
    cs_field_rom #(.BYTE_IDX_W(BYTE_IDX_W)) rom_scan_i (
        .byte_idx (scan_idx[IDX_W-1:3]),
        .chan     (scan_chan),
        .crc_a    (8'h00),
        .crc_b    (8'h00),
        .byte_val (scan_byte)
    );

    assign scan_bit = scan_byte[scan_idx[2:0]];

    cs_crc_seq #(.FRAMES(FRAMES)) crc_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .data_bit  (scan_bit),
        .scan_idx  (scan_idx),
        .scan_chan (scan_chan),
        .crc_a     (crc_a_w),
        .crc_b     (crc_b_w),
        .done      (crc_done)
    );

    // contents seen by the transmitter
    cs_field_rom #(.BYTE_IDX_W(BYTE_IDX_W)) rom_read_i (
        .byte_idx (frame_idx[IDX_W-1:3]),
        .chan     (chan_sel),
        .crc_a    (crc_a_w),
        .crc_b    (crc_b_w),
        .byte_val (rd_byte)
    );

    always_comb begin
        ready      = crc_done;
        status_bit = crc_done && (frame_idx < IDX_W'(FRAMES)) && rd_byte[frame_idx[2:0]];
    end
endmodule

// File: rtl/cs_bit_gen_chk.sv
module cs_bit_gen_chk #(
    parameter int FRAMES = 192,
    localparam int IDX_W = $clog2(FRAMES)
) (
    input logic             clk,
    input logic             rst_n,
    input logic [IDX_W-1:0] frame_idx,
    input logic             status_bit,
    input logic             ready,
    input logic [7:0]       crc_a,
    input logic [7:0]       crc_b
);
    logic [15:0] cyc_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 cyc_cnt <= '0;
        else if (cyc_cnt != 16'hFFFF) cyc_cnt <= cyc_cnt + 1'b1;
    end

    assert_gated_until_ready_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !ready |-> !status_bit);

    assert_ready_timing_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready) |-> (cyc_cnt == 16'(2 * FRAMES)));

    assert_ready_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ready |=> ready);

    assert_crc_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ready |=> ($stable(crc_a) && $stable(crc_b)));

    assert_out_of_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_idx >= IDX_W'(FRAMES)) |-> !status_bit);
endmodule

bind cs_bit_gen cs_bit_gen_chk #(.FRAMES(FRAMES)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .frame_idx  (frame_idx),
    .status_bit (status_bit),
    .ready      (ready),
    .crc_a      (crc_a_w),
    .crc_b      (crc_b_w)
);

// File: tb/cs_bit_gen_tb.sv
`timescale 1ns/1ps
module cs_bit_gen_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] frame_idx = '0;
    logic       chan_sel = 1'b0;
    logic       status_bit, ready;
    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    cs_bit_gen dut_i (
        .clk(clk), .rst_n(rst_n), .frame_idx(frame_idx),
        .chan_sel(chan_sel), .status_bit(status_bit), .ready(ready)
    );

    function automatic logic [7:0] fixed_byte(logic ch, int b);
        if (b == 0) return 8'h04;
        if (b == 2) return ch ? 8'h20 : 8'h10;
        if (b == 3) return 8'h03;
        return 8'h00;
    endfunction

    function automatic logic [7:0] model_crc(logic ch);
        logic [7:0] c = 8'hFF;
        for (int b = 0; b < 24; b++) begin
            logic [7:0] d = (b == 23) ? 8'h00 : fixed_byte(ch, b);
            for (int j = 0; j < 8; j++) begin
                if (c[0] ^ d[j]) c = (c >> 1) ^ 8'hB8;
                else             c = c >> 1;
            end
        end
        return c;
    endfunction

    function automatic logic model_bit(logic ch, int n);
        logic [7:0] v = (n / 8 == 23) ? model_crc(ch) : fixed_byte(ch, n / 8);
        return v[n % 8];
    endfunction

    function automatic string req_of(int n);
        int b = n / 8;
        if (b == 0)  return "R4";
        if (b == 2)  return "R6";
        if (b == 3)  return "R7";
        if (b == 23) return "R8";
        return "R5";
    endfunction

    task automatic check(string req, logic act, logic exp, string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
        end
    endtask

    task automatic read_bit(logic ch, int n, output logic v);
        @(negedge clk);
        chan_sel  = ch;
        frame_idx = 8'(n);
        #1;
        v = status_bit;
    endtask

    // R1: held reset, then early reads while the CRC walk runs
    task automatic t_reset_gating();
        logic v;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        frame_idx = 8'd2; chan_sel = 1'b0; #1;
        check("R1", ready, 1'b0, "ready in reset");
        check("R1", status_bit, 1'b0, "bit in reset frame 2");
        @(negedge clk);
        rst_n = 1'b1;
        read_bit(1'b0, 2, v);
        check("R1", v, 1'b0, "bit gated frame 2 before ready");
        read_bit(1'b1, 21, v);
        check("R1", v, 1'b0, "bit gated frame 21 before ready");
    endtask

    // R2: ready exactly after edge 384 from release
    task automatic t_ready_timing();
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        repeat (383) @(posedge clk);
        @(negedge clk);
        check("R2", ready, 1'b0, "ready after 383 edges");
        @(posedge clk);
        @(negedge clk);
        check("R2", ready, 1'b1, "ready after 384 edges");
        repeat (20) @(negedge clk);
        check("R2", ready, 1'b1, "ready held");
    endtask

    // R3: LSB-first mapping spot checks
    task automatic t_mapping();
        logic v;
        read_bit(1'b0, 2, v);  check("R3", v, 1'b1, "frame 2 chan A");
        read_bit(1'b0, 5, v);  check("R3", v, 1'b0, "frame 5 chan A");
        read_bit(1'b0, 20, v); check("R3", v, 1'b1, "frame 20 chan A");
        read_bit(1'b0, 23, v); check("R3", v, 1'b0, "frame 23 chan A");
        read_bit(1'b1, 24, v); check("R3", v, 1'b1, "frame 24 chan B");
        read_bit(1'b1, 31, v); check("R3", v, 1'b0, "frame 31 chan B");
    endtask

    // R4..R8: full sweep of one channel
    task automatic t_sweep(logic ch);
        logic v;
        for (int n = 0; n < 192; n++) begin
            read_bit(ch, n, v);
            checks++;
            if (v !== model_bit(ch, n)) begin
                errors++;
                $display("FAIL %s chan=%0b frame=%0d actual=%b expected=%b",
                         req_of(n), ch, n, v, model_bit(ch, n));
            end
        end
    endtask

    // R8: CRC byte assembled from frames 184..191
    task automatic t_crc_byte(logic ch);
        logic v;
        logic [7:0] got;
        for (int j = 0; j < 8; j++) begin
            read_bit(ch, 184 + j, v);
            got[j] = v;
        end
        checks++;
        if (got !== model_crc(ch)) begin
            errors++;
            $display("FAIL R8 crc chan=%0b actual=%02h expected=%02h", ch, got, model_crc(ch));
        end
    endtask

    // R9: indexes past the block read zero
    task automatic t_out_of_range();
        logic v;
        for (int n = 192; n < 256; n++) begin
            read_bit(n[0], n, v);
            check("R9", v, 1'b0, $sformatf("frame %0d", n));
        end
    endtask

    initial begin
        #(8 * 150000);
        errors++;
        $display("FAIL R2 watchdog actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        t_reset_gating();
        t_ready_timing();
        t_mapping();
        t_sweep(1'b0);
        t_sweep(1'b1);
        t_crc_byte(1'b0);
        t_crc_byte(1'b1);
        t_out_of_range();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule